// File: doc/BRIEF.md
# CAN Error Warning and Transmit Buffer Status

This block holds the error-warning and transmit-buffer status logic of a CAN controller's register interface. An 8-bit warning limit sits in a register that software may read at any time. It may only be loaded while the controller's reset-mode input is high. Outside reset mode the limit is checked against the transmit and receive error counters, which arrive as inputs. The result is an error-status bit. When that bit changes and the interrupt enable is high, a one-cycle warning interrupt pulse is raised. While reset mode is high the error-status bit is frozen. The effect of a newly loaded limit therefore shows up only once reset mode is left.

The block also tracks three transmit buffers. Each buffer has a released flag and a transmission-complete flag. A buffer locks itself when a transmission is requested on it, and it unlocks when its completion pulse arrives. While a buffer is locked, software writes to its frame-info, identifier and data registers are refused. Entering reset mode aborts pending transmissions and releases every buffer.

A packed status word combines these flags with three receive-side bits. The receive-side bits are mirrored from a global status source. All pins are plain control and status signals. No stream interface is involved, so there is no back-pressure.

Top module: `can_errwarn_txstat`

## Requirements
- R1: After reset the limit reads 0x60 (decimal 96), all three buffers read released=1 and complete=1, and err_status and warn_irq are 0.
- R2: A limit write (lim_wr_en) loads lim_wr_data on the next edge only while reset_mode is 1. A write with reset_mode 0 leaves lim_rd unchanged. lim_rd always shows the stored limit.
- R3: While reset_mode is 0, err_status after each edge equals (tx_err_cnt >= limit) OR (rx_err_cnt >= limit), using the counters and the limit that were present at that edge.
- R4: While reset_mode is 1, err_status holds its value. A limit loaded in reset mode changes err_status only on the first edge at which reset_mode is 0.
- R5: warn_irq is 1 for exactly the cycle after an edge at which reset_mode was 0, warn_irq_en was 1 and err_status changed value. In every other cycle it is 0.
- R6: Outside reset mode, tx_req[i] on a released buffer clears buf_released[i] and tx_complete[i] on the next edge. tx_req[i] on a locked buffer has no effect.
- R7: tx_done[i] on a locked buffer outside reset mode sets buf_released[i] and tx_complete[i] on the next edge. tx_done[i] on a released buffer has no effect.
- R8: On any edge with reset_mode 1, all buffers become released, tx_complete is unchanged, and tx_req and tx_done are ignored.
- R9: buf_wr_ok[i] equals buf_wr_en[i] AND buf_released[i] in the same cycle, so writes to a locked buffer are refused.
- R10: status_word holds one 8-bit group per buffer i at bits [8i+7:8i]. In each group, bit0 is released[i], bit1 is complete[i], bit2 is gsr_rx_buf, bit3 is gsr_overrun, bit4 is gsr_rx_active, and bits 7:5 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_mode | input | 1 | Controller reset-mode bit |
| lim_wr_en | input | 1 | Warning-limit write strobe |
| lim_wr_data | input | 8 | Warning-limit write value |
| lim_rd | output | 8 | Stored warning limit |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| warn_irq_en | input | 1 | Error-warning interrupt enable |
| err_status | output | 1 | Error-status bit |
| warn_irq | output | 1 | One-cycle error-warning interrupt |
| tx_req | input | 3 | Per-buffer transmit request |
| tx_done | input | 3 | Per-buffer successful-completion pulse |
| buf_wr_en | input | 3 | Per-buffer software register write attempt |
| buf_wr_ok | output | 3 | Per-buffer write accepted |
| buf_released | output | 3 | Per-buffer released (1) / locked (0) |
| tx_complete | output | 3 | Per-buffer last transmission complete |
| gsr_rx_buf | input | 1 | Mirrored receive-buffer status |
| gsr_overrun | input | 1 | Mirrored data-overrun status |
| gsr_rx_active | input | 1 | Mirrored receive status |
| status_word | output | 24 | Packed per-buffer status groups |

## Verification
The limit, err_status, warn_irq, buf_released and tx_complete are registered. Each takes its new value one edge after the stimulus that causes it. buf_wr_ok, lim_rd and status_word follow their sources combinationally in the same cycle. The bench drives inputs just after a falling edge and compares all outputs at the next falling edge. It checks them against a reference model that the bench advances on the rising edge between the two. Directed sequences cover the reset-mode freeze and the release of the deferred status, and they check both results on the first cycle after the mode input falls.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int unsigned TXB_NUM      = 3;
  localparam int unsigned ECNT_W       = 8;
  localparam int unsigned GRP_W        = 8;
  localparam logic [7:0]  WARN_LIM_RST = 8'd96;

  typedef struct packed {
    logic released;
    logic complete;
  } txb_flags_t;
endpackage

// File: rtl/warn_limit_reg.sv
module warn_limit_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reset_mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] limit
);
  logic [W-1:0] lim_q;

  // Loads are accepted only while the controller sits in reset mode.
  always_ff @(posedge clk) begin
    if (!rst_n)                    lim_q <= INIT;
    else if (reset_mode && wr_en)  lim_q <= wr_data;
  end

  assign limit = lim_q;
endmodule

// File: rtl/err_warn_eval.sv
module err_warn_eval #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reset_mode,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] tx_cnt,
  input  logic [W-1:0] rx_cnt,
  input  logic         irq_en,
  output logic         err_status,
  output logic         warn_irq
);
  logic hit;
  logic es_q, irq_q;
  logic change;

  assign hit    = (tx_cnt >= limit) || (rx_cnt >= limit);
  assign change = !reset_mode && (hit != es_q);

  // Status is frozen in reset mode, so a new limit acts only after exit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      es_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (change) es_q <= hit;
      irq_q <= change && irq_en;
    end
  end

  assign err_status = es_q;
  assign warn_irq   = irq_q;
endmodule

// File: rtl/txbuf_flags.sv
module txbuf_flags
  import can_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_mode,
  input  logic       req,
  input  logic       done,
  input  logic       sw_wr,
  output txb_flags_t flags,
  output logic       sw_wr_ok
);
  txb_flags_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q.released <= 1'b1;
      st_q.complete <= 1'b1;
    end else if (reset_mode) begin
      // Abort: release the buffer, keep the completion flag.
      st_q.released <= 1'b1;
    end else if (req && st_q.released) begin
      st_q.released <= 1'b0;
      st_q.complete <= 1'b0;
    end else if (done && !st_q.released) begin
      st_q.released <= 1'b1;
      st_q.complete <= 1'b1;
    end
  end

  assign flags    = st_q;
  assign sw_wr_ok = sw_wr && st_q.released;
endmodule

// File: rtl/can_errwarn_txstat.sv
module can_errwarn_txstat
  import can_stat_pkg::*;
#(
  parameter int unsigned NBUF  = TXB_NUM,
  parameter int unsigned CW    = ECNT_W,
  parameter int unsigned GW    = GRP_W,
  parameter logic [CW-1:0] LIM_INIT = WARN_LIM_RST
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reset_mode,
  input  logic           lim_wr_en,
  input  logic [CW-1:0]  lim_wr_data,
  output logic [CW-1:0]  lim_rd,
  input  logic [CW-1:0]  tx_err_cnt,
  input  logic [CW-1:0]  rx_err_cnt,
  input  logic           warn_irq_en,
  output logic           err_status,
  output logic           warn_irq,
  input  logic [NBUF-1:0] tx_req,
  input  logic [NBUF-1:0] tx_done,
  input  logic [NBUF-1:0] buf_wr_en,
  output logic [NBUF-1:0] buf_wr_ok,
  output logic [NBUF-1:0] buf_released,
  output logic [NBUF-1:0] tx_complete,
  input  logic           gsr_rx_buf,
  input  logic           gsr_overrun,
  input  logic           gsr_rx_active,
  output logic [NBUF*GW-1:0] status_word
);
  localparam int unsigned USED_BITS = 5;
  localparam int unsigned PAD_BITS  = GW - USED_BITS;

  logic [CW-1:0] limit;

  warn_limit_reg #(.W(CW), .INIT(LIM_INIT)) u_lim (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_mode (reset_mode),
    .wr_en      (lim_wr_en),
    .wr_data    (lim_wr_data),
    .limit      (limit)
  );

  assign lim_rd = limit;

  err_warn_eval #(.W(CW)) u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_mode (reset_mode),
    .limit      (limit),
    .tx_cnt     (tx_err_cnt),
    .rx_cnt     (rx_err_cnt),
    .irq_en     (warn_irq_en),
    .err_status (err_status),
    .warn_irq   (warn_irq)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    txb_flags_t fl;

    txbuf_flags u_txb (
      .clk        (clk),
      .rst_n      (rst_n),
      .reset_mode (reset_mode),
      .req        (tx_req[b]),
      .done       (tx_done[b]),
      .sw_wr      (buf_wr_en[b]),
      .flags      (fl),
      .sw_wr_ok   (buf_wr_ok[b])
    );

    assign buf_released[b] = fl.released;
    assign tx_complete[b]  = fl.complete;
    assign status_word[b*GW +: GW] =
      {{PAD_BITS{1'b0}}, gsr_rx_active, gsr_overrun, gsr_rx_buf,
       fl.complete, fl.released};
  end
endmodule

// File: rtl/can_stat_chk.sv
module can_stat_chk #(
  parameter int unsigned NB = 3,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reset_mode,
  input logic          lim_wr_en,
  input logic [CW-1:0] lim_rd,
  input logic          warn_irq_en,
  input logic          err_status,
  input logic          warn_irq,
  input logic [NB-1:0] tx_req,
  input logic [NB-1:0] buf_released,
  input logic [NB-1:0] tx_complete
);
  // R2
  lim_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lim_rd) |-> $past(reset_mode && lim_wr_en));

  // R4
  stat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reset_mode) |-> $stable(err_status));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> ($past(!reset_mode && warn_irq_en) && (err_status != $past(err_status))));

  // R8
  mode_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |=> (&buf_released));

  for (genvar g = 0; g < NB; g++) begin : g_lock
    // R6
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_released[g]) |-> ($past(tx_req[g] && !reset_mode) && !tx_complete[g]));
  end
endmodule

bind can_errwarn_txstat can_stat_chk #(.NB(NBUF), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reset_mode   (reset_mode),
  .lim_wr_en    (lim_wr_en),
  .lim_rd       (lim_rd),
  .warn_irq_en  (warn_irq_en),
  .err_status   (err_status),
  .warn_irq     (warn_irq),
  .tx_req       (tx_req),
  .buf_released (buf_released),
  .tx_complete  (tx_complete)
);

// File: tb/sim_can_errwarn_txstat.sv
`timescale 1ns/1ps
module sim_can_errwarn_txstat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rm = 1'b0, lw = 1'b0, ien = 1'b0;
  logic [7:0] ld = '0, txc = '0, rxc = '0;
  logic [2:0] req = '0, done = '0, bwe = '0;
  logic g_rb = 1'b0, g_ov = 1'b0, g_ra = 1'b0;
  logic [7:0] lim_rd;
  logic es, irq;
  logic [2:0] wr_ok, rel, cmp;
  logic [23:0] sw;

  int checks = 0;
  int fails  = 0;
  logic done_flag = 1'b0;

  // reference state
  logic [7:0] m_lim;
  logic m_es, m_irq;
  logic [2:0] m_rel, m_cmp;

  always #2.5 clk = ~clk;

  can_errwarn_txstat u0 (
    .clk(clk), .rst_n(rst_n), .reset_mode(rm),
    .lim_wr_en(lw), .lim_wr_data(ld), .lim_rd(lim_rd),
    .tx_err_cnt(txc), .rx_err_cnt(rxc), .warn_irq_en(ien),
    .err_status(es), .warn_irq(irq),
    .tx_req(req), .tx_done(done), .buf_wr_en(bwe), .buf_wr_ok(wr_ok),
    .buf_released(rel), .tx_complete(cmp),
    .gsr_rx_buf(g_rb), .gsr_overrun(g_ov), .gsr_rx_active(g_ra),
    .status_word(sw)
  );

  function automatic logic f_hit(logic [7:0] t, logic [7:0] r, logic [7:0] l);
    return (t >= l) || (r >= l);
  endfunction

  function automatic logic [23:0] f_word(logic [2:0] r, logic [2:0] c,
                                         logic b, logic o, logic a);
    logic [23:0] w;
    for (int i = 0; i < 3; i++) w[i*8 +: 8] = {3'b000, a, o, b, c[i], r[i]};
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lim <= 8'h60; m_es <= 1'b0; m_irq <= 1'b0;
      m_rel <= 3'b111; m_cmp <= 3'b111;
    end else begin
      logic h;
      h = f_hit(txc, rxc, m_lim);
      if (rm && lw) m_lim <= ld;
      if (!rm && h != m_es) m_es <= h;
      m_irq <= !rm && (h != m_es) && ien;
      for (int i = 0; i < 3; i++) begin
        if (rm) m_rel[i] <= 1'b1;
        else if (req[i] && m_rel[i]) begin m_rel[i] <= 1'b0; m_cmp[i] <= 1'b0; end
        else if (done[i] && !m_rel[i]) begin m_rel[i] <= 1'b1; m_cmp[i] <= 1'b1; end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R2 lim_rd", 32'(lim_rd), 32'(m_lim));
    check("R3 err_status", 32'(es), 32'(m_es));
    check("R5 warn_irq", 32'(irq), 32'(m_irq));
    check("R6 buf_released", 32'(rel), 32'(m_rel));
    check("R7 tx_complete", 32'(cmp), 32'(m_cmp));
    check("R9 buf_wr_ok", 32'(wr_ok), 32'(bwe & m_rel));
    check("R10 status_word", 32'(sw), 32'(f_word(m_rel, m_cmp, g_rb, g_ov, g_ra)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 lim", 32'(lim_rd), 32'h60);
    check("R1 released", 32'(rel), 32'h7);
    check("R1 complete", 32'(cmp), 32'h7);
    check("R1 err/irq", 32'({es, irq}), 32'h0);
    // R2 write outside reset mode ignored
    lw = 1'b1; ld = 8'h10;
    step();
    check("R2 ignored write", 32'(lim_rd), 32'h60);
    lw = 1'b0; rm = 1'b1;
    step();
    lw = 1'b1;
    step();
    check("R2 reset-mode write", 32'(lim_rd), 32'h10);
    lw = 1'b0; txc = 8'h20;
    step(); step();
    check("R4 frozen in reset mode", 32'(es), 32'h0);
    rm = 1'b0; ien = 1'b1;
    step();
    check("R4 status after exit", 32'(es), 32'h1);
    check("R5 irq pulse", 32'(irq), 32'h1);
    step();
    check("R5 irq one cycle", 32'(irq), 32'h0);
    // R6 / R9 / R7 directed buffer 0
    req = 3'b001;
    step();
    check("R6 lock buf0", 32'({rel[0], cmp[0]}), 32'h0);
    req = 3'b000; bwe = 3'b001;
    step();
    check("R9 refused write", 32'(wr_ok), 32'h0);
    done = 3'b001; bwe = 3'b000;
    step();
    check("R7 release buf0", 32'({rel[0], cmp[0]}), 32'h3);
    // R8 abort in reset mode keeps completion flag
    done = 3'b000; req = 3'b110;
    step();
    req = 3'b000; rm = 1'b1;
    step();
    check("R8 released", 32'(rel), 32'h7);
    check("R8 complete kept", 32'(cmp), 32'h1);
    rm = 1'b0;
    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 25 == 0) rm = ~rm;
      lw   = ($urandom % 4) == 0;
      ld   = 8'($urandom % 128);
      txc  = 8'($urandom % 160);
      rxc  = 8'($urandom % 160);
      ien  = ($urandom % 4) != 0;
      req  = 3'($urandom);
      done = 3'($urandom);
      bwe  = 3'($urandom);
      g_rb = 1'($urandom); g_ov = 1'($urandom); g_ra = 1'($urandom);
      step();
    end
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule